// File: doc/BRIEF.md
# Side-by-Side Superframe Video Splitter

This block accepts a single video stream in which every active line carries two equal-size images placed next to each other. The first `halfWidth` active pixels of a line belong to the left image and the next `halfWidth` to the right image. Internally the line is regrouped into an interleaved left/right order: left pixel 0, right pixel 0, left pixel 1, right pixel 1, and so on. That interleaved sequence is then dealt alternately to two output ports, so port A rebuilds the left image and port B rebuilds the right image. Each port receives one pixel on every second clock, which is half the input pixel rate.

Both ports share one set of timing outputs. These are the horizontal sync, vertical sync and data-enable inputs, delayed by the same number of cycles as the pixel path, so both images keep identical line and frame timing. A line store keeps the incoming pixels long enough for each right-image pixel to be paired with its left-image partner. A sticky flag reports any active line whose length is not twice the configured half width.

Top module: `sf_pixel_splitter`

## Requirements
- R1: While reset is asserted, and after reset until the first line is processed, `pixA`, `pixB`, `validA`, `validB`, `syncHs`, `syncVs`, `syncDe` and `lenErr` are all 0.
- R2: For a line whose first active pixel is sampled at clock edge P0, the left-image pixel in column k (k < halfWidth) is presented on `pixA` with `validA` high in the cycle after edge P0 + halfWidth + 2k, in column order.
- R3: The right-image pixel in column halfWidth + k is presented on `pixB` with `validB` high in the cycle after edge P0 + halfWidth + 2k + 1. Every `validB` pulse directly follows a `validA` pulse.
- R4: `validA` and `validB` are never high together, and neither is high in two consecutive cycles.
- R5: `syncDe` equals `deIn` delayed by halfWidth clock cycles. The valid strobes are only asserted while `syncDe` is high.
- R6: `syncHs` and `syncVs` equal `hsIn` and `vsIn` delayed by the same halfWidth cycles as `syncDe`.
- R7: When an active line (a run of `deIn` high) ends with a length other than 2 × halfWidth, `lenErr` rises and stays high until reset. Lines of correct length leave it at 0.
- R8: Lines separated by a single blanking cycle are split without corrupting either image. This holds for half widths from 1 up to the parameter maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | PIX_W | Incoming superframe pixel |
| hsIn | input | 1 | Incoming horizontal sync |
| vsIn | input | 1 | Incoming vertical sync; also restarts the line write position |
| deIn | input | 1 | Incoming active-video qualifier |
| halfWidth | input | $clog2(MAX_HALF+1) | Pixels per line of one image; 1 to MAX_HALF; held stable while video runs |
| pixA | output | PIX_W | Left-image pixel |
| validA | output | 1 | Qualifies `pixA` |
| pixB | output | PIX_W | Right-image pixel |
| validB | output | 1 | Qualifies `pixB` |
| syncHs | output | 1 | Delayed horizontal sync for both images |
| syncVs | output | 1 | Delayed vertical sync for both images |
| syncDe | output | 1 | Delayed data-enable window for both images |
| lenErr | output | 1 | Sticky line-length mismatch flag |

## Verification
Some properties are checked by assertions on every cycle. These cover the mutual exclusion and strict alternation of the two valid strobes, the rule that a right pixel only follows a left one, the confinement of the strobes to the delayed data-enable window, the stickiness of the error flag and the bound on the write position. Other behaviour can only be shown by the bench scenarios. These include which pixel value leaves on which port in which cycle, the exact sync delay for a given half width, the single-cycle-blanking case at the smallest and largest widths, and the rise of the error flag after a short line.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef struct packed {
    logic wrEn;
    logic rdAct;
    logic rdOdd;
  } strobe_t;

  typedef struct packed {
    logic vs;
    logic hs;
    logic de;
  } sync_t;

endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int MAX_HALF = 64,
  localparam int AW = $clog2(2 * MAX_HALF),
  localparam int HW = $clog2(MAX_HALF + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hsIn,
  input  logic          vsIn,
  input  logic          deIn,
  input  logic [HW-1:0] halfWidth,
  output strobe_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output sync_t         syncOut,
  output logic          lenErr
);

  localparam int LINE_MAX = 2 * MAX_HALF;

  logic [HW-1:0] hwC;
  logic [AW:0]   wrCol;
  logic [AW:0]   rdStep;
  logic [AW-1:0] pairIdx;
  logic          prevDe;
  sync_t         dly [MAX_HALF+1];
  sync_t         tapRd;

  // clamp the configured width into the supported range
  always_comb begin
    if (halfWidth == '0)                  hwC = HW'(1);
    else if (halfWidth > HW'(MAX_HALF))   hwC = HW'(MAX_HALF);
    else                                  hwC = halfWidth;
  end

  // timing delay line: element d holds inputs sampled d+1 edges ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= MAX_HALF; i++) dly[i] <= '0;
    end else begin
      dly[0] <= '{vs: vsIn, hs: hsIn, de: deIn};
      for (int i = 1; i <= MAX_HALF; i++) dly[i] <= dly[i-1];
    end
  end

  assign tapRd   = dly[hwC - HW'(1)];
  assign syncOut = dly[hwC];

  // write side: column counter restarts outside active video and on VSYNC
  assign stb.wrEn = deIn && (wrCol < (AW+1)'(LINE_MAX));
  assign wrAddr   = wrCol[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCol  <= '0;
      prevDe <= 1'b0;
      lenErr <= 1'b0;
    end else begin
      prevDe <= deIn;
      if (vsIn || !deIn)  wrCol <= '0;
      else if (stb.wrEn)  wrCol <= wrCol + 1'b1;
      if (prevDe && !deIn && (wrCol != (AW+1)'({hwC, 1'b0})))
        lenErr <= 1'b1;
    end
  end

  // read side: interleave left/right once the delayed window opens
  assign stb.rdAct = tapRd.de;
  assign stb.rdOdd = rdStep[0];
  assign pairIdx   = rdStep[AW:1];
  assign rdAddr    = stb.rdOdd ? (AW'(hwC) + pairIdx) : pairIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      rdStep <= '0;
    else if (!tapRd.de || tapRd.vs) rdStep <= '0;
    else                            rdStep <= rdStep + 1'b1;
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |=> lenErr);

  assert_wr_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrCol <= (AW+1)'(LINE_MAX));

endmodule

// File: rtl/sps_data.sv
module sps_data
  import sps_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int MAX_HALF = 64,
  localparam int AW    = $clog2(2 * MAX_HALF),
  localparam int DEPTH = 2 * MAX_HALF
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] pixA,
  output logic             validA,
  output logic [PIX_W-1:0] pixB,
  output logic             validB
);

  logic [PIX_W-1:0] lineMem [DEPTH];
  logic [PIX_W-1:0] rdPix;

  always_ff @(posedge clk) begin
    if (stb.wrEn) lineMem[wrAddr] <= pixIn;
  end

  assign rdPix = lineMem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixA   <= '0;
      pixB   <= '0;
      validA <= 1'b0;
      validB <= 1'b0;
    end else begin
      validA <= stb.rdAct && !stb.rdOdd;
      validB <= stb.rdAct &&  stb.rdOdd;
      if (stb.rdAct && !stb.rdOdd) pixA <= rdPix;
      if (stb.rdAct &&  stb.rdOdd) pixB <= rdPix;
    end
  end

  assert_valid_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(validA && validB));

  assert_a_half_rate_R4: assert property (@(posedge clk) disable iff (!rstN)
    validA |=> !validA);

  assert_b_half_rate_R4: assert property (@(posedge clk) disable iff (!rstN)
    validB |=> !validB);

  assert_b_after_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    validB |-> $past(validA));

endmodule

// File: rtl/sf_pixel_splitter.sv
module sf_pixel_splitter
  import sps_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int MAX_HALF = 64,
  localparam int AW = $clog2(2 * MAX_HALF),
  localparam int HW = $clog2(MAX_HALF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             deIn,
  input  logic [HW-1:0]    halfWidth,
  output logic [PIX_W-1:0] pixA,
  output logic             validA,
  output logic [PIX_W-1:0] pixB,
  output logic             validB,
  output logic             syncHs,
  output logic             syncVs,
  output logic             syncDe,
  output logic             lenErr
);

  strobe_t       stb;
  sync_t         syncOut;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  sps_ctrl #(.MAX_HALF(MAX_HALF)) ctrl_i (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .halfWidth(halfWidth), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .syncOut(syncOut), .lenErr(lenErr)
  );

  sps_data #(.PIX_W(PIX_W), .MAX_HALF(MAX_HALF)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .pixIn(pixIn), .pixA(pixA), .validA(validA), .pixB(pixB), .validB(validB)
  );

  assign syncHs = syncOut.hs;
  assign syncVs = syncOut.vs;
  assign syncDe = syncOut.de;

  assert_valid_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validA || validB) |-> syncDe);

endmodule

// File: tb/sf_pixel_splitter_tb_top.sv
`timescale 1ns/1ps
module sf_pixel_splitter_tb_top;

  localparam int PIX_W    = 16;
  localparam int MAX_HALF = 64;
  localparam int HW       = $clog2(MAX_HALF + 1);

  typedef struct {
    logic [PIX_W-1:0] pix;
    int               at;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN;
  logic [PIX_W-1:0] pixIn;
  logic             hsIn, vsIn, deIn;
  logic [HW-1:0]    halfWidth;
  logic [PIX_W-1:0] pixA, pixB;
  logic             validA, validB, syncHs, syncVs, syncDe, lenErr;

  int   cyc = 0;
  int   cfgCyc = 0;
  int   nChecks = 0;
  int   nFail = 0;
  bit   mute = 1'b0;
  bit   finished = 1'b0;
  logic [2:0] ring [256];
  exp_t qA [$];
  exp_t qB [$];

  always #2.5 clk = ~clk;

  sf_pixel_splitter #(.PIX_W(PIX_W), .MAX_HALF(MAX_HALF)) dut_i (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .hsIn(hsIn), .vsIn(vsIn),
    .deIn(deIn), .halfWidth(halfWidth), .pixA(pixA), .validA(validA),
    .pixB(pixB), .validB(validB), .syncHs(syncHs), .syncVs(syncVs),
    .syncDe(syncDe), .lenErr(lenErr)
  );

  always @(posedge clk) begin
    ring[(cyc + 1) & 255] <= {vsIn, hsIn, deIn};
    cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      exp_t e;
      if (validA && validB) check(1'b0, "R4", "both valids high", 1, 0);
      if ((validA || validB) && !syncDe) check(1'b0, "R5", "valid outside window", 0, 1);
      if (!mute && validA) begin
        if (qA.size() == 0) check(1'b0, "R2", "unexpected validA", cyc, -1);
        else begin
          e = qA.pop_front();
          check(pixA == e.pix, "R2", "pixA value", pixA, e.pix);
          check(cyc == e.at, "R2", "validA cycle", cyc, e.at);
        end
      end
      if (!mute && validB) begin
        if (qB.size() == 0) check(1'b0, "R3", "unexpected validB", cyc, -1);
        else begin
          e = qB.pop_front();
          check(pixB == e.pix, "R3", "pixB value", pixB, e.pix);
          check(cyc == e.at, "R3", "validB cycle", cyc, e.at);
        end
      end
      if (cyc - cfgCyc > MAX_HALF + 2) begin
        logic [2:0] r;
        r = ring[(cyc - int'(halfWidth)) & 255];
        check(syncDe == r[0], "R5", "syncDe delay", syncDe, r[0]);
        check(syncHs == r[1], "R6", "syncHs delay", syncHs, r[1]);
        check(syncVs == r[2], "R6", "syncVs delay", syncVs, r[2]);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      deIn = 1'b0; hsIn = 1'b0; vsIn = 1'b0; pixIn = '0;
    end
  endtask

  task automatic vsyncPulse();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      deIn = 1'b0; vsIn = 1'b1; hsIn = 1'b0;
    end
    idle(4);
  endtask

  task automatic setWidth(input int n);
    idle(MAX_HALF * 3 + 4);
    @(negedge clk);
    halfWidth = HW'(n);
    cfgCyc = cyc;
    idle(2);
  endtask

  // driver: one active line of len pixels followed by blank cycles
  task automatic sendLine(input int n, input int len, input int tag, input int blank);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == 0 && len == 2 * n) begin
        int p0;
        p0 = cyc + 1;
        for (int k = 0; k < n; k++) begin
          qA.push_back('{pix: PIX_W'(tag * 256 + k),     at: p0 + n + 2 * k});
          qB.push_back('{pix: PIX_W'(tag * 256 + n + k), at: p0 + n + 2 * k + 1});
        end
      end
      deIn = 1'b1; hsIn = 1'b0; vsIn = 1'b0;
      pixIn = PIX_W'(tag * 256 + c);
    end
    for (int b = 0; b < blank; b++) begin
      @(negedge clk);
      deIn = 1'b0; hsIn = (b == 0); pixIn = '0;
    end
  endtask

  initial begin
    rstN = 1'b0; pixIn = '0; hsIn = 1'b0; vsIn = 1'b0; deIn = 1'b0;
    halfWidth = HW'(4);
    repeat (5) @(negedge clk);
    // R1: reset state
    check({pixA, pixB} == '0, "R1", "pixels in reset", {pixA, pixB}, 0);
    check({validA, validB, syncHs, syncVs, syncDe, lenErr} == '0, "R1",
          "flags in reset", {validA, validB, syncHs, syncVs, syncDe, lenErr}, 0);
    rstN = 1'b1;
    cfgCyc = cyc;
    idle(3);
    check({validA, validB, syncDe, lenErr} == '0, "R1", "idle after reset",
          {validA, validB, syncDe, lenErr}, 0);

    // R2 R3 R6: width 4, several lines with frame sync
    vsyncPulse();
    for (int t = 1; t <= 3; t++) sendLine(4, 8, t, 6);
    idle(80);

    // R8: width 1, single-cycle blanking
    setWidth(1);
    vsyncPulse();
    for (int t = 10; t < 16; t++) sendLine(1, 2, t, 1);
    idle(10);

    // R8: width 3, single-cycle blanking (output window overlaps next input line)
    setWidth(3);
    vsyncPulse();
    for (int t = 20; t < 25; t++) sendLine(3, 6, t, 1);
    idle(20);

    // R8: maximum width, back-to-back lines
    setWidth(MAX_HALF);
    vsyncPulse();
    sendLine(MAX_HALF, 2 * MAX_HALF, 40, 1);
    sendLine(MAX_HALF, 2 * MAX_HALF, 41, 3);
    idle(3 * MAX_HALF + 10);
    check(lenErr == 1'b0, "R7", "no error on correct lines", lenErr, 0);

    // R7: short line raises the sticky flag
    setWidth(4);
    mute = 1'b1;
    sendLine(4, 6, 50, 4);
    idle(20);
    mute = 1'b0;
    check(lenErr == 1'b1, "R7", "error after short line", lenErr, 1);
    sendLine(4, 8, 51, 6);
    idle(30);
    check(lenErr == 1'b1, "R7", "error stays high", lenErr, 1);

    idle(40);
    check(qA.size() == 0, "R2", "left pixels outstanding", qA.size(), 0);
    check(qB.size() == 0, "R3", "right pixels outstanding", qB.size(), 0);

    // R1: a fresh reset clears the flag
    @(negedge clk);
    rstN = 1'b0;
    cfgCyc = cyc;
    idle(2);
    check(lenErr == 1'b0 && syncDe == 1'b0, "R1", "state after second reset",
          {lenErr, syncDe}, 0);
    rstN = 1'b1;
    idle(2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule